// File: doc/BRIEF.md
# Completion Entry Posting Sequencer

This block drives the bus-master port of an add-in card's DMA engine to deliver one completion record to host memory. A record is a 64-byte entry plus two host addresses. The block first writes the entry as one burst. It then writes a single 32-bit sequence number to a separate doorbell address. After that it raises an interrupt. Each step starts only after the bus engine has reported the previous transaction fully done. The host driver can therefore trust that a new doorbell value means the entry has already landed.

Two configuration bits are sampled when a record is accepted. The first selects the plain memory-write command in place of the block memory-write command. The second turns on a verify step: a block read of the entry, issued between the entry write and the doorbell. Its returned beats are compared with what was written. Any difference sets a sticky stale-data flag. An aborted transaction is issued again from its first beat, and the sequence does not move on.

Top module: `cmpl_post_seq`

## Requirements
- R1: `rec_ready` is high only while the block is idle. A record (entry, entry address, doorbell address, configuration bits) is taken on a cycle with `rec_valid` and `rec_ready` both high. `rec_valid` while busy has no effect on any transaction.
- R2: The first transaction of a record has address = entry address and `bm_len` = 64. It sends 8 beats in order, beat i carrying entry bits [64i+63:64i], one beat per cycle with `bm_wready` high. Its command is block memory write (4'b1111) when `cfg_plain_wr` was 0.
- R3: With `cfg_plain_wr` = 1 at acceptance, both the entry write and the doorbell write use the plain memory-write command (4'b0111).
- R4: The doorbell write follows the entry write's `bm_done` (or the verify read's `bm_done`). It goes to the doorbell address with `bm_len` = 4 and one beat. Bits [31:0] of that beat hold the sequence number, bits [63:32] are zero. The first record after reset carries 1, and each later record carries one more.
- R5: `irq` rises in the cycle after the doorbell's `bm_done`. It stays high until a cycle with `irq_clr` high. A clear in the same cycle as a new set loses to the set.
- R6: `bm_no_snoop` and `bm_relaxed_ord` are 0 on every request.
- R7: With `cfg_verify` = 1, a block read (4'b1110) to the entry address with `bm_len` = 64 is issued between the entry write and the doorbell. Its `bm_rvalid` beats may arrive at any latency.
- R8: If any read-back beat differs from the written beat of the same index, `stale_err` goes high in the cycle after that read's `bm_done`. It stays high until reset. A matching read-back leaves it low.
- R9: `bm_abort` on a request drops `bm_req` for exactly one cycle. The same transaction (command, address, length) is then reissued from beat 0, and the sequence does not advance.
- R10: After reset: `rec_ready` = 1, `bm_req` = 0, `irq` = 0, `stale_err` = 0.
- R11: After the doorbell completes, no request is made until a new record is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_plain_wr | input | 1 | Use plain memory write instead of block memory write |
| cfg_verify | input | 1 | Insert read-back of the entry before the doorbell |
| rec_valid | input | 1 | Record offered |
| rec_ready | output | 1 | Block idle, record can be taken |
| rec_entry | input | 512 | Entry contents, beat i in bits [64i+63:64i] |
| rec_entry_addr | input | 64 | Host address of the entry |
| rec_bell_addr | input | 64 | Host address of the doorbell |
| bm_req | output | 1 | Transaction request, held until done or abort |
| bm_cmd | output | 4 | Bus command code |
| bm_addr | output | 64 | Transaction address |
| bm_len | output | 7 | Transaction length in bytes |
| bm_no_snoop | output | 1 | No-snoop attribute, always 0 |
| bm_relaxed_ord | output | 1 | Relaxed-ordering attribute, always 0 |
| bm_wdata | output | 64 | Current write beat |
| bm_wready | input | 1 | Write beat taken this cycle |
| bm_rvalid | input | 1 | Read beat present this cycle |
| bm_rdata | input | 64 | Read beat data |
| bm_done | input | 1 | Current transaction finished |
| bm_abort | input | 1 | Current transaction aborted |
| irq | output | 1 | Interrupt to host |
| irq_clr | input | 1 | Interrupt acknowledge pulse |
| stale_err | output | 1 | Sticky read-back mismatch flag |

## Verification
A wrong beat counter shows up on `bm_wdata` at the very next accepted beat. It also makes the read-back compare fail, so `stale_err` rises one cycle after a read whose data matched. A state register that skips or repeats a step is seen at the next request edge, as a command or address that does not match the expected transaction order. It is also seen as a request after the doorbell, or as an early `irq`. A wrong sequence counter appears in the first doorbell beat that uses it, and a lost abort retry appears in the cycle after the abort, as a missing gap or a beat other than 0.

// File: rtl/cpsq_pkg.sv
package cpsq_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ENTRY  = 2'd1,
        ST_VERIFY = 2'd2,
        ST_BELL   = 2'd3
    } cpsq_state_e;

    localparam logic [3:0] CMD_MEM_WR     = 4'b0111;
    localparam logic [3:0] CMD_MEM_WR_BLK = 4'b1111;
    localparam logic [3:0] CMD_MEM_RD_BLK = 4'b1110;
endpackage

// File: rtl/cpsq_entry_buf.sv
module cpsq_entry_buf #(
    parameter int BEAT_W = 64,
    parameter int BEATS  = 8,
    parameter int SEL_W  = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    load,
    input  logic [BEAT_W*BEATS-1:0] din,
    input  logic [SEL_W-1:0]        sel,
    output logic [BEAT_W-1:0]       dout
);
    logic [BEAT_W-1:0] word_q [BEATS];

    for (genvar g = 0; g < BEATS; g++) begin : g_word
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                word_q[g] <= '0;
            end else if (load) begin
                word_q[g] <= din[g*BEAT_W +: BEAT_W];
            end
        end
    end

    always_comb begin
        dout = '0;
        for (int i = 0; i < BEATS; i++) begin
            if (sel == SEL_W'(i)) begin
                dout = word_q[i];
            end
        end
    end
endmodule

// File: rtl/cpsq_verify.sv
module cpsq_verify #(
    parameter int BEAT_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active,
    input  logic              rvalid,
    input  logic [BEAT_W-1:0] rdata,
    input  logic [BEAT_W-1:0] expect_w,
    input  logic              done,
    input  logic              abort,
    output logic              stale_err
);
    typedef struct packed {
        logic mism;
        logic stale;
    } vst_t;

    vst_t q, n;

    always_comb begin
        n = q;
        if (active) begin
            if (rvalid && (rdata != expect_w)) begin
                n.mism = 1'b1;
            end
            if (abort) begin
                n.mism = 1'b0;
            end else if (done) begin
                n.stale = q.stale | n.mism;
                n.mism  = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= n;
        end
    end

    assign stale_err = q.stale;
endmodule

// File: rtl/cmpl_post_seq.sv
module cmpl_post_seq
    import cpsq_pkg::*;
#(
    parameter int ADDR_W      = 64,
    parameter int BEAT_W      = 64,
    parameter int ENTRY_BYTES = 64,
    parameter int SEQ_W       = 32,
    parameter int BELL_BYTES  = 4
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               cfg_plain_wr,
    input  logic                               cfg_verify,
    input  logic                               rec_valid,
    output logic                               rec_ready,
    input  logic [ENTRY_BYTES*8-1:0]           rec_entry,
    input  logic [ADDR_W-1:0]                  rec_entry_addr,
    input  logic [ADDR_W-1:0]                  rec_bell_addr,
    output logic                               bm_req,
    output logic [3:0]                         bm_cmd,
    output logic [ADDR_W-1:0]                  bm_addr,
    output logic [$clog2(ENTRY_BYTES+1)-1:0]   bm_len,
    output logic                               bm_no_snoop,
    output logic                               bm_relaxed_ord,
    output logic [BEAT_W-1:0]                  bm_wdata,
    input  logic                               bm_wready,
    input  logic                               bm_rvalid,
    input  logic [BEAT_W-1:0]                  bm_rdata,
    input  logic                               bm_done,
    input  logic                               bm_abort,
    output logic                               irq,
    input  logic                               irq_clr,
    output logic                               stale_err
);
    localparam int ENTRY_W = ENTRY_BYTES * 8;
    localparam int BEATS   = ENTRY_W / BEAT_W;
    localparam int SEL_W   = (BEATS > 1) ? $clog2(BEATS) : 1;
    localparam int LEN_W   = $clog2(ENTRY_BYTES + 1);

    typedef struct packed {
        cpsq_state_e       state;
        logic [SEL_W-1:0]  beat;
        logic              gap;
        logic [SEQ_W-1:0]  seq;
        logic              irq;
        logic [ADDR_W-1:0] ent_addr;
        logic [ADDR_W-1:0] bell_addr;
        logic              plain;
        logic              verify;
    } ctl_t;

    ctl_t q, n;

    logic              live;
    logic              accept;
    logic              in_verify;
    logic              beat_step;
    logic [BEAT_W-1:0] buf_word;
    logic [3:0]        wr_cmd;

    assign live      = (q.state != ST_IDLE) && !q.gap;
    assign accept    = (q.state == ST_IDLE) && rec_valid;
    assign in_verify = live && (q.state == ST_VERIFY);
    assign beat_step = in_verify ? bm_rvalid : bm_wready;
    assign wr_cmd    = q.plain ? CMD_MEM_WR : CMD_MEM_WR_BLK;

    cpsq_entry_buf #(
        .BEAT_W (BEAT_W),
        .BEATS  (BEATS),
        .SEL_W  (SEL_W)
    ) u_buf (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (accept),
        .din   (rec_entry),
        .sel   (q.beat),
        .dout  (buf_word)
    );

    cpsq_verify #(
        .BEAT_W (BEAT_W)
    ) u_verify (
        .clk       (clk),
        .rst_n     (rst_n),
        .active    (in_verify),
        .rvalid    (bm_rvalid),
        .rdata     (bm_rdata),
        .expect_w  (buf_word),
        .done      (bm_done),
        .abort     (bm_abort),
        .stale_err (stale_err)
    );

    always_comb begin
        n     = q;
        n.gap = 1'b0;
        if (irq_clr) begin
            n.irq = 1'b0;
        end
        if (q.state == ST_IDLE) begin
            if (rec_valid) begin
                n.state     = ST_ENTRY;
                n.beat      = '0;
                n.seq       = q.seq + SEQ_W'(1);
                n.ent_addr  = rec_entry_addr;
                n.bell_addr = rec_bell_addr;
                n.plain     = cfg_plain_wr;
                n.verify    = cfg_verify;
            end
        end else if (live) begin
            if (bm_abort) begin
                n.gap  = 1'b1;
                n.beat = '0;
            end else if (bm_done) begin
                n.beat = '0;
                case (q.state)
                    ST_ENTRY:  n.state = q.verify ? ST_VERIFY : ST_BELL;
                    ST_VERIFY: n.state = ST_BELL;
                    default: begin
                        n.state = ST_IDLE;
                        n.irq   = 1'b1;
                    end
                endcase
            end else if (beat_step) begin
                n.beat = q.beat + SEL_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.state <= ST_IDLE;
        end else begin
            q <= n;
        end
    end

    always_comb begin
        bm_cmd   = wr_cmd;
        bm_addr  = q.ent_addr;
        bm_len   = LEN_W'(ENTRY_BYTES);
        bm_wdata = '0;
        case (q.state)
            ST_ENTRY:  bm_wdata = buf_word;
            ST_VERIFY: bm_cmd   = CMD_MEM_RD_BLK;
            ST_BELL: begin
                bm_addr  = q.bell_addr;
                bm_len   = LEN_W'(BELL_BYTES);
                bm_wdata = {{(BEAT_W-SEQ_W){1'b0}}, q.seq};
            end
            default: ;
        endcase
    end

    assign bm_req         = live;
    assign rec_ready      = (q.state == ST_IDLE);
    assign bm_no_snoop    = 1'b0;
    assign bm_relaxed_ord = 1'b0;
    assign irq            = q.irq;
endmodule

// File: rtl/cpsq_checker.sv
module cpsq_checker #(
    parameter int ADDR_W = 64,
    parameter int LEN_W  = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rec_ready,
    input logic              bm_req,
    input logic [3:0]        bm_cmd,
    input logic [ADDR_W-1:0] bm_addr,
    input logic [LEN_W-1:0]  bm_len,
    input logic              bm_done,
    input logic              bm_abort,
    input logic              irq,
    input logic              irq_clr,
    input logic              stale_err
);
    // R1: no request while the block advertises idle
    a_r1_idle_no_req: assert property (@(posedge clk) disable iff (!rst_n)
        rec_ready |-> !bm_req);

    // R2: request fields stay put until the transaction ends
    a_r2_hdr_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (bm_req && !bm_done && !bm_abort) |=>
            (bm_req && $stable(bm_cmd) && $stable(bm_addr) && $stable(bm_len)));

    // R5: interrupt holds until acknowledged
    a_r5_irq_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !irq_clr) |=> irq);

    // R5: interrupt rises only right after a completed doorbell write
    a_r5_irq_after_bell: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(bm_req && bm_done && !bm_abort && bm_len == LEN_W'(4)
                             && bm_cmd != 4'b1110));

    // R8: stale flag is sticky
    a_r8_stale_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        stale_err |=> stale_err);

    // R9: an abort leaves a one-cycle gap, then the same transaction returns
    a_r9_abort_reissue: assert property (@(posedge clk) disable iff (!rst_n)
        (bm_req && bm_abort) |=> (!bm_req ##1 (bm_req && bm_cmd == $past(bm_cmd, 2)
                                           && bm_addr == $past(bm_addr, 2))));
endmodule

bind cmpl_post_seq cpsq_checker #(
    .ADDR_W (ADDR_W),
    .LEN_W  ($clog2(ENTRY_BYTES+1))
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rec_ready (rec_ready),
    .bm_req    (bm_req),
    .bm_cmd    (bm_cmd),
    .bm_addr   (bm_addr),
    .bm_len    (bm_len),
    .bm_done   (bm_done),
    .bm_abort  (bm_abort),
    .irq       (irq),
    .irq_clr   (irq_clr),
    .stale_err (stale_err)
);

// File: tb/cmpl_post_seq_tb.sv
module cmpl_post_seq_tb;
    localparam int K_ENTRY = 0;
    localparam int K_READ  = 1;
    localparam int K_BELL  = 2;

    typedef struct {
        logic [3:0]  cmd;
        logic [63:0] addr;
        logic [6:0]  len;
        int          nb;
        int          kind;
        logic [63:0] w [8];
    } txn_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cfg_plain_wr = 1'b0, cfg_verify = 1'b0;
    logic         rec_valid = 1'b0;
    logic         rec_ready;
    logic [511:0] rec_entry = '0;
    logic [63:0]  rec_entry_addr = '0, rec_bell_addr = '0;
    logic         bm_req;
    logic [3:0]   bm_cmd;
    logic [63:0]  bm_addr;
    logic [6:0]   bm_len;
    logic         bm_no_snoop, bm_relaxed_ord;
    logic [63:0]  bm_wdata;
    logic         bm_wready = 1'b0, bm_rvalid = 1'b0, bm_done = 1'b0, bm_abort = 1'b0;
    logic [63:0]  bm_rdata = '0;
    logic         irq;
    logic         irq_clr = 1'b0;
    logic         stale_err;

    always #10 clk = ~clk;

    cmpl_post_seq u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_plain_wr(cfg_plain_wr), .cfg_verify(cfg_verify),
        .rec_valid(rec_valid), .rec_ready(rec_ready), .rec_entry(rec_entry),
        .rec_entry_addr(rec_entry_addr), .rec_bell_addr(rec_bell_addr),
        .bm_req(bm_req), .bm_cmd(bm_cmd), .bm_addr(bm_addr), .bm_len(bm_len),
        .bm_no_snoop(bm_no_snoop), .bm_relaxed_ord(bm_relaxed_ord), .bm_wdata(bm_wdata),
        .bm_wready(bm_wready), .bm_rvalid(bm_rvalid), .bm_rdata(bm_rdata),
        .bm_done(bm_done), .bm_abort(bm_abort), .irq(irq), .irq_clr(irq_clr),
        .stale_err(stale_err)
    );

    int tests = 0;
    int fails = 0;

    txn_t        q[$];
    logic [63:0] host_mem [8];
    logic [63:0] exp_seq = '0;
    bit exp_ready = 1'b1, exp_irq = 1'b0, exp_stale = 1'b0;
    bit pend_accept = 0, pend_set = 0, pend_clr = 0, pend_stale = 0, pend_gap = 0;
    bit in_txn = 0, mism = 0;
    int given = 0, lat = 0;
    bit want_rec = 0, want_clr = 0, lost_write = 0;
    int stray_left = 0;
    int abort_kind = -1, abort_at = 0;
    bit abort_used = 0;
    logic [511:0] w_entry;
    logic [63:0]  w_eaddr, w_baddr;
    bit w_plain, w_verify;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic push_record();
        txn_t t;
        logic [3:0] wc;
        wc = w_plain ? 4'b0111 : 4'b1111;
        exp_seq = exp_seq + 1;
        t.cmd = wc; t.addr = w_eaddr; t.len = 7'd64; t.nb = 8; t.kind = K_ENTRY;
        for (int i = 0; i < 8; i++) t.w[i] = w_entry[i*64 +: 64];
        q.push_back(t);
        if (w_verify) begin
            t.cmd = 4'b1110; t.kind = K_READ;
            q.push_back(t);
        end
        t.cmd = wc; t.addr = w_baddr; t.len = 7'd4; t.nb = 1; t.kind = K_BELL;
        t.w[0] = {32'h0, exp_seq[31:0]};
        q.push_back(t);
    endtask

    task automatic cycle();
        string hr;
        @(negedge clk);
        if (pend_accept) begin
            push_record();
            exp_ready = 1'b0;
            want_rec = 1'b0;
        end
        if (pend_set) exp_irq = 1'b1;
        else if (pend_clr) exp_irq = 1'b0;
        if (pend_set) exp_ready = 1'b1;
        if (pend_stale) exp_stale = 1'b1;
        if (pend_gap) chk(bm_req == 1'b0, "R9", "gap after abort", 64'(bm_req), 64'd0);
        pend_accept = 0; pend_set = 0; pend_clr = 0; pend_stale = 0; pend_gap = 0;

        chk(rec_ready == exp_ready, "R1", "rec_ready", 64'(rec_ready), 64'(exp_ready));
        chk(irq == exp_irq, "R5", "irq", 64'(irq), 64'(exp_irq));
        chk(stale_err == exp_stale, "R8", "stale_err", 64'(stale_err), 64'(exp_stale));

        bm_wready = 0; bm_done = 0; bm_abort = 0; bm_rvalid = 0; bm_rdata = '0;
        if (bm_req) begin
            chk(!bm_no_snoop && !bm_relaxed_ord, "R6", "attributes",
                {62'd0, bm_no_snoop, bm_relaxed_ord}, 64'd0);
            if (!in_txn) begin
                if (q.size() == 0) begin
                    chk(1'b0, "R11", "request with nothing pending", 64'(bm_cmd), 64'd0);
                end else begin
                    hr = (q[0].kind == K_READ) ? "R7" :
                         (q[0].kind == K_BELL) ? "R4" : (w_plain ? "R3" : "R2");
                    chk(bm_cmd == q[0].cmd, hr, "command", 64'(bm_cmd), 64'(q[0].cmd));
                    chk(bm_addr == q[0].addr, hr, "address", bm_addr, q[0].addr);
                    chk(bm_len == q[0].len, hr, "length", 64'(bm_len), 64'(q[0].len));
                    in_txn = 1; given = 0; lat = 0; mism = 0;
                end
            end
            if (in_txn) begin
                if (!abort_used && q[0].kind == abort_kind && given == abort_at) begin
                    bm_abort = 1; in_txn = 0; abort_used = 1; pend_gap = 1;
                end else if (q[0].kind != K_READ) begin
                    if (given < q[0].nb) begin
                        bm_wready = 1;
                        chk(bm_wdata == q[0].w[given], (q[0].kind == K_BELL) ? "R4" : "R2",
                            "write beat", bm_wdata, q[0].w[given]);
                        if (q[0].kind == K_ENTRY && !lost_write) host_mem[given] = bm_wdata;
                        given++;
                    end else begin
                        bm_done = 1; in_txn = 0;
                        if (q[0].kind == K_BELL) pend_set = 1;
                        void'(q.pop_front());
                    end
                end else begin
                    if (lat < 3) lat++;
                    else if (given < 8) begin
                        bm_rvalid = 1; bm_rdata = host_mem[given];
                        if (host_mem[given] != q[0].w[given]) mism = 1;
                        given++;
                    end else begin
                        bm_done = 1; in_txn = 0;
                        if (mism) pend_stale = 1;
                        void'(q.pop_front());
                    end
                end
            end
        end

        irq_clr = want_clr;
        pend_clr = want_clr;
        if (want_rec && exp_ready) begin
            rec_valid = 1; rec_entry = w_entry; rec_entry_addr = w_eaddr;
            rec_bell_addr = w_baddr; cfg_plain_wr = w_plain; cfg_verify = w_verify;
            pend_accept = 1;
        end else if (stray_left > 0) begin
            stray_left--;
            rec_valid = 1; rec_entry = {8{64'hDEAD_0000_BAD0_0000}};
            rec_entry_addr = 64'hFFFF_0000; rec_bell_addr = 64'hFFFF_1000;
            cfg_plain_wr = 1; cfg_verify = 1;
        end else begin
            rec_valid = 0;
        end
    endtask

    task automatic post(input logic [31:0] seed, input bit plain, input bit verify,
                        input bit lost, input int akind, input int aat,
                        input int stray, input bit clr_hold);
        for (int i = 0; i < 8; i++) w_entry[i*64 +: 64] = {seed, 32'(i) ^ seed};
        w_eaddr = {32'h0, seed} << 6;
        w_baddr = 64'h8000_0000 + 64'(seed);
        w_plain = plain; w_verify = verify; lost_write = lost;
        abort_kind = akind; abort_at = aat; abort_used = 0;
        want_rec = 1; want_clr = clr_hold;
        cycle();
        stray_left = stray;
        cycle();
        while (!(exp_ready && q.size() == 0 && !in_txn)) cycle();
        // R5: interrupt stays high without an acknowledge
        repeat (3) cycle();
        want_clr = 1;
        cycle();
        want_clr = 0;
        repeat (3) cycle();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", tests, 0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 8; i++) host_mem[i] = 64'h5A5A_5A5A_0000_0000 | 64'(i);
        repeat (4) @(posedge clk);
        @(negedge clk);
        // R10: reset state
        chk(rec_ready == 1'b1, "R10", "rec_ready at reset", 64'(rec_ready), 64'd1);
        chk(bm_req == 1'b0, "R10", "bm_req at reset", 64'(bm_req), 64'd0);
        chk(irq == 1'b0, "R10", "irq at reset", 64'(irq), 64'd0);
        chk(stale_err == 1'b0, "R10", "stale at reset", 64'(stale_err), 64'd0);
        rst_n = 1'b1;
        repeat (2) cycle();

        post(32'h0000_0011, 0, 0, 0, -1, 0, 0, 0);   // R2 R4 R5 default block write
        post(32'h0000_0022, 1, 0, 0, -1, 0, 6, 0);   // R3 plain write, R1 stray valid
        post(32'h0000_0033, 0, 1, 0, -1, 0, 0, 0);   // R7 read-back matches, R8 stays low
        post(32'h0000_0044, 0, 0, 0, K_ENTRY, 3, 0, 0); // R9 abort mid entry
        post(32'h0000_0055, 0, 1, 0, K_READ, 2, 0, 0);  // R9 abort in read-back
        post(32'h0000_0066, 1, 0, 0, K_BELL, 0, 0, 0);  // R9 abort on doorbell
        post(32'h0000_0077, 0, 0, 0, K_ENTRY, 0, 0, 1); // R5 set beats held clear
        post(32'h0000_0088, 0, 1, 1, -1, 0, 0, 0);   // R8 lost write gives stale flag
        post(32'h0000_0099, 0, 1, 0, -1, 0, 0, 0);   // R8 flag stays latched
        repeat (5) cycle();                           // R11 idle, no request

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule